// File: doc/BRIEF.md
# Two-Half Level Interrupt Controller

This block gathers 64 level-sensitive interrupt sources into two 32-bit halves. Sources 0 to 31 form the low half and sources 32 to 63 form the high half. Each half has a cause register that latches the asserted sources and a CPU mask register that enables them. The block combines the enabled pending bits into a single CPU interrupt line. Four high-half inputs (bits 24 to 27 of that half) carry summary lines from a general-purpose-pin interrupt unit. Together with the 32 pin interrupts behind those lines, the system has 96 interrupt numbers.

Software services the line by reading one select-cause word. That word returns the enabled pending bits of one half, and a flag in bit 30 tells which half they come from. The low half takes precedence, so an interrupt handler needs only one read to find the half to service. During initialisation software writes the masks and then writes zero to both cause registers. Access uses a plain 32-bit register port: a byte address, a write enable, write data, and combinational read data.

Top module: `irq_pair_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both cause registers read 0, the low mask reads 0, the high mask reads 0x0F000000, and the interrupt output is 0.
- R2: The registers are at these byte offsets: low cause 0x04, high cause 0x0C, low mask 0x14, high mask 0x1C, select cause 0x24. Source i (0..31) maps to bit i of the low half. Source 32+i maps to bit i of the high half.
- R3: If a source is high at a clock edge, its cause bit reads 1 after that edge. The bit stays 1 for as long as the source stays high.
- R4: A write to a cause register clears each bit written as 0 only if that bit's source is low at the same edge. Bits written as 1, and bits whose source is high, keep their value.
- R5: A write to a mask register replaces its whole value from the write data at that edge. A mask bit of 1 enables its source.
- R6: When the low half has any enabled pending bit (cause AND mask), select cause returns the low cause AND low mask with bit 30 forced to 0.
- R7: When the low half has no enabled pending bit, select cause returns the high cause AND high mask with bit 30 forced to 1. The high half's own bit 30 is never shown there, and with nothing pending the word is 0x40000000.
- R8: The interrupt output is 1 in the cycle after an edge at which any half has a bit set in both cause and mask, and 0 otherwise.
- R9: A read from any offset other than the five listed returns 0. A write to such an offset changes no register.
- R10: After reset, with no mask write, asserting any of high-half bits 24 to 27 raises the interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from register state |
| irq_src | input | 64 | Raw level-sensitive sources, bit 0 is source 0 |
| cpu_irq | output | 1 | Registered CPU interrupt request |

## Verification
Register state is due one edge after its cause. A source that is high at edge k, or a write at edge k, shows in the cause, mask and select-cause reads just after edge k. The interrupt output reacts one edge later, at k+1. The bench drives inputs on the falling edge and compares the read data and the interrupt line against a behavioural model shortly after that falling edge. The model advances its register image at each rising edge and computes its interrupt value from the state held before that edge, which gives the interrupt line its one-edge lag. A mixed pseudo-random phase is checked on every cycle against the same model.

// File: rtl/irq_pair_pkg.sv
// Package: shared constants and types for the two-half interrupt controller.
// Assumes a 32-bit data path and an 8-bit byte-offset register space.
package irq_pair_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned N_HALVES = 2;
    localparam int unsigned SRC_W    = DATA_W * N_HALVES;
    localparam int unsigned FLAG_BIT = 30;

    localparam logic [ADDR_W-1:0] OFS_CAUSE_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAUSE_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SELECT   = 8'h24;

    localparam logic [DATA_W-1:0] MASK_LO_RST = 32'h0000_0000;
    localparam logic [DATA_W-1:0] MASK_HI_RST = 32'h0F00_0000;

    typedef enum logic [2:0] {
        RS_NONE     = 3'd0,
        RS_CAUSE_LO = 3'd1,
        RS_CAUSE_HI = 3'd2,
        RS_MASK_LO  = 3'd3,
        RS_MASK_HI  = 3'd4,
        RS_SELECT   = 3'd5
    } reg_slot_e;

    typedef struct packed {
        logic [N_HALVES-1:0] cause_wr;
        logic [N_HALVES-1:0] mask_wr;
    } wr_strobe_t;

endpackage

// File: rtl/irq_pair_decode.sv
// Module: irq_pair_decode
// Turns a byte offset into a register slot and per-half write strobes.
// Assumes a single-cycle bus with no wait states. Unmapped offsets give
// RS_NONE and raise no strobe, so reads and writes there have no effect.
module irq_pair_decode
    import irq_pair_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output reg_slot_e         slot_o,
    output wr_strobe_t        strobe_o
);

    // Purpose: map the offset to a slot.
    always_comb begin
        case (addr_i)
            OFS_CAUSE_LO: slot_o = RS_CAUSE_LO;
            OFS_CAUSE_HI: slot_o = RS_CAUSE_HI;
            OFS_MASK_LO:  slot_o = RS_MASK_LO;
            OFS_MASK_HI:  slot_o = RS_MASK_HI;
            OFS_SELECT:   slot_o = RS_SELECT;
            default:      slot_o = RS_NONE;
        endcase
    end

    // Purpose: qualify the slot with the write enable, one strobe per half.
    always_comb begin
        strobe_o.cause_wr[0] = we_i && (slot_o == RS_CAUSE_LO);
        strobe_o.cause_wr[1] = we_i && (slot_o == RS_CAUSE_HI);
        strobe_o.mask_wr[0]  = we_i && (slot_o == RS_MASK_LO);
        strobe_o.mask_wr[1]  = we_i && (slot_o == RS_MASK_HI);
    end

endmodule

// File: rtl/irq_pair_bank.sv
// Module: irq_pair_bank
// One 32-bit half: a cause register that latches level sources, and a CPU
// mask register. A cause bit is set while its source is high. A write of 0
// to a bit clears it only if the source is low at the same edge.
// Assumes sources are already synchronous to clk.
module irq_pair_bank
    import irq_pair_pkg::*;
#(
    parameter logic [DATA_W-1:0] MASK_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              cause_wr_i,
    input  logic              mask_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cause_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] pend_o
);

    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] clr_bits;

    // Purpose: bits software asks to drop in this cycle (written as 0).
    always_comb begin
        clr_bits = cause_wr_i ? ~wdata_i : '0;
    end

    // Purpose: cause register, the live level wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= src_i | (cause_q & ~clr_bits);
        end
    end

    // Purpose: mask register, replaced whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RESET;
        end else if (mask_wr_i) begin
            mask_q <= wdata_i;
        end
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign pend_o  = cause_q & mask_q;

    // R3: every source high at an edge is visible in cause after it.
    p_level_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(src_i)) == $past(src_i)));

    // R4: a bit can only drop if its source was low and a cause write happened.
    p_clear_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(cause_q) & ~cause_q) & $past(src_i)) == '0));

    p_clear_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr_i |=> ((~$past(cause_q) | cause_q) == '1));

    // R5: without a write strobe the mask keeps its value.
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_q));

endmodule

// File: rtl/irq_pair_select.sv
// Module: irq_pair_select
// Builds the select-cause word from the enabled pending bits of both halves.
// The low half has precedence. Bit FLAG_BIT is the half flag and is
// overridden in both cases.
module irq_pair_select
    import irq_pair_pkg::*;
(
    input  logic [DATA_W-1:0] pend_lo_i,
    input  logic [DATA_W-1:0] pend_hi_i,
    output logic [DATA_W-1:0] word_o,
    output logic              any_o
);

    logic [DATA_W-1:0] flag_bit;
    logic              lo_active;

    assign flag_bit  = DATA_W'(1) << FLAG_BIT;
    assign lo_active = |pend_lo_i;

    // Purpose: pick the half and stamp the flag.
    always_comb begin
        if (lo_active) begin
            word_o = pend_lo_i & ~flag_bit;
        end else begin
            word_o = pend_hi_i | flag_bit;
        end
    end

    // Purpose: any enabled pending bit in either half.
    assign any_o = lo_active | (|pend_hi_i);

endmodule

// File: rtl/irq_pair_ctrl.sv
// Module: irq_pair_ctrl (top)
// Two-half level interrupt controller with a register port and one
// registered CPU interrupt line. Assumes synchronous sources and a
// single-cycle register bus. Read data is combinational from state.
module irq_pair_ctrl
    import irq_pair_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [63:0] irq_src,
    output logic        cpu_irq
);

    localparam logic [DATA_W-1:0] MASK_RST [N_HALVES] = '{MASK_LO_RST, MASK_HI_RST};

    reg_slot_e         slot;
    wr_strobe_t        strobe;
    logic [DATA_W-1:0] cause [N_HALVES];
    logic [DATA_W-1:0] mask  [N_HALVES];
    logic [DATA_W-1:0] pend  [N_HALVES];
    logic [DATA_W-1:0] sel_word;
    logic              any_pend;
    logic              irq_q;

    irq_pair_decode u_dec (
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .slot_o   (slot),
        .strobe_o (strobe)
    );

    // Purpose: one bank per half, each with its own mask reset value.
    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        irq_pair_bank #(
            .MASK_RESET (MASK_RST[h])
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (irq_src[h*DATA_W +: DATA_W]),
            .cause_wr_i (strobe.cause_wr[h]),
            .mask_wr_i  (strobe.mask_wr[h]),
            .wdata_i    (bus_wdata),
            .cause_o    (cause[h]),
            .mask_o     (mask[h]),
            .pend_o     (pend[h])
        );
    end

    irq_pair_select u_sel (
        .pend_lo_i (pend[0]),
        .pend_hi_i (pend[1]),
        .word_o    (sel_word),
        .any_o     (any_pend)
    );

    // Purpose: read data mux, zero for unmapped offsets.
    always_comb begin
        case (slot)
            RS_CAUSE_LO: bus_rdata = cause[0];
            RS_CAUSE_HI: bus_rdata = cause[1];
            RS_MASK_LO:  bus_rdata = mask[0];
            RS_MASK_HI:  bus_rdata = mask[1];
            RS_SELECT:   bus_rdata = sel_word;
            default:     bus_rdata = '0;
        endcase
    end

    // Purpose: register the combined request for the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_pend;
        end
    end

    assign cpu_irq = irq_q;

    // R8: a reported pending bit raises the line one edge later.
    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_word & ~(DATA_W'(1) << FLAG_BIT)) != '0) |=> cpu_irq);

    // R8: with nothing enabled and pending in either bank, the line drops.
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause[0] & mask[0]) == '0 && (cause[1] & mask[1]) == '0) |=> !cpu_irq);

    // R7: the high-half flag implies the low half has nothing enabled pending.
    p_flag_means_low_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_word[FLAG_BIT] |-> ((cause[0] & mask[0]) == '0));

    // R6: with low pending, the high flag is never shown.
    p_low_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause[0] & mask[0]) != '0) |-> !sel_word[FLAG_BIT]);

endmodule

// File: tb/irq_pair_ctrl_test.sv
// Bench: behavioural reference model checked on every cycle.
module irq_pair_ctrl_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Model state
    logic [31:0] m_cause_lo, m_cause_hi, m_mask_lo, m_mask_hi;
    logic        m_irq;

    irq_pair_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .cpu_irq   (cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] pl, ph;
        pl = m_cause_lo & m_mask_lo;
        ph = m_cause_hi & m_mask_hi;
        case (a)
            8'h04: return m_cause_lo;
            8'h0C: return m_cause_hi;
            8'h14: return m_mask_lo;
            8'h1C: return m_mask_hi;
            8'h24: begin
                if (pl != 0) return pl & 32'hBFFF_FFFF;
                else         return ph | 32'h4000_0000;
            end
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h04, 8'h0C: return "R3/R4 cause";
            8'h14, 8'h1C: return "R5 mask";
            8'h24:        return "R6/R7 select";
            default:      return "R9 unmapped";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: compare after inputs settle, then advance the model at the edge.
    task automatic tick();
        logic [31:0] clr;
        #1;
        check(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
        check("R8 cpu_irq", {31'b0, cpu_irq}, {31'b0, m_irq});
        @(posedge clk);
        m_irq = ((m_cause_lo & m_mask_lo) != 0) || ((m_cause_hi & m_mask_hi) != 0);
        clr = ~bus_wdata;
        if (bus_we && bus_addr == 8'h04) m_cause_lo = irq_src[31:0]  | (m_cause_lo & ~clr);
        else                             m_cause_lo = irq_src[31:0]  | m_cause_lo;
        if (bus_we && bus_addr == 8'h0C) m_cause_hi = irq_src[63:32] | (m_cause_hi & ~clr);
        else                             m_cause_hi = irq_src[63:32] | m_cause_hi;
        if (bus_we && bus_addr == 8'h14) m_mask_lo = bus_wdata;
        if (bus_we && bus_addr == 8'h1C) m_mask_hi = bus_wdata;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_expect(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        m_cause_lo = '0; m_cause_hi = '0; m_mask_lo = '0;
        m_mask_hi = 32'h0F00_0000; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 offsets
        rd_expect("R1 cause lo", 8'h04, 32'h0);
        rd_expect("R1 cause hi", 8'h0C, 32'h0);
        rd_expect("R1 mask lo",  8'h14, 32'h0);
        rd_expect("R1 mask hi",  8'h1C, 32'h0F00_0000);
        check("R1 irq", {31'b0, cpu_irq}, 32'h0);

        // R3 / R2: low source 3 latches, but masked so no irq
        irq_src[3] = 1'b1;
        rd_expect("R3 cause lo set", 8'h04, 32'h0);
        rd_expect("R3 cause lo held", 8'h04, 32'h8);
        check("R8 masked no irq", {31'b0, cpu_irq}, 32'h0);

        // R5 enable low bit 3, R8 irq next edge
        wr(8'h14, 32'h0000_0008);
        rd_expect("R5 mask lo", 8'h14, 32'h8);
        check("R8 irq raised", {31'b0, cpu_irq}, 32'h1);
        rd_expect("R6 select low", 8'h24, 32'h8);

        // R6: high pin group pending, low still wins
        irq_src[57] = 1'b1;
        tick();
        rd_expect("R6 low precedence", 8'h24, 32'h8);
        rd_expect("R2 cause hi bit 25", 8'h0C, 32'h0200_0000);

        // R4: clear while source high keeps the bit
        wr(8'h04, 32'h0);
        rd_expect("R4 held while high", 8'h04, 32'h8);
        irq_src[3] = 1'b0;
        wr(8'h04, 32'hFFFF_FFFF);
        rd_expect("R4 one bits no effect", 8'h04, 32'h8);
        wr(8'h04, 32'h0);
        rd_expect("R4 cleared", 8'h04, 32'h0);

        // R7 / R10: high pin group drives irq from reset mask
        rd_expect("R7 select high", 8'h24, 32'h4200_0000);
        check("R10 pin group irq", {31'b0, cpu_irq}, 32'h1);

        // R7: high bit 30 hidden
        irq_src[62] = 1'b1;
        irq_src[57] = 1'b0;
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0);
        rd_expect("R7 bit30 hidden", 8'h24, 32'h4000_0000);
        rd_expect("R7 cause hi bit30", 8'h0C, 32'h4000_0000);
        irq_src[62] = 1'b0;
        wr(8'h0C, 32'h0);
        tick();
        rd_expect("R7 empty select", 8'h24, 32'h4000_0000);
        check("R8 irq low", {31'b0, cpu_irq}, 32'h0);

        // R9: unmapped offsets
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_expect("R9 unmapped read", 8'h08, 32'h0);
        rd_expect("R9 unmapped 0x28", 8'h28, 32'h0);
        rd_expect("R9 mask lo untouched", 8'h14, 32'h8);
        rd_expect("R9 mask hi untouched", 8'h1C, 32'hFFFF_FFFF);

        // Mixed phase: pseudo-random sources, writes and reads
        lfsr = 32'hACE1_2357;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            irq_src = {lfsr & {lfsr[7:0], lfsr[31:8]}, lfsr & {lfsr[15:0], lfsr[31:16]}};
            case (lfsr[4:2])
                3'd0: bus_addr = 8'h04;
                3'd1: bus_addr = 8'h0C;
                3'd2: bus_addr = 8'h14;
                3'd3: bus_addr = 8'h1C;
                3'd4: bus_addr = 8'h24;
                3'd5: bus_addr = 8'h10;
                default: bus_addr = 8'h24;
            endcase
            bus_we    = lfsr[9] & lfsr[13];
            bus_wdata = {lfsr[15:0], lfsr[31:16]};
            tick();
        end
        bus_we = 1'b0;

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule